// File: doc/BRIEF.md
# DMA Burst Request Controller

This block raises the DMA request line for one peripheral buffer and paces it in bursts. Software sets a burst length in bytes through a small register port. The DMA side then moves data one bus cycle at a time. Each cycle is signalled by a strobe. The block drops the request at the end of every burst and raises it again on the next clock if bytes remain. When the whole transfer has been moved, the request stays low and a one-cycle done pulse is given.

Two bus modes are supported. In the narrow mode each strobe moves 2 bytes. In the wide mode each strobe moves 4 bytes. The burst length is forced onto a multiple of that step, so a short burst setting makes the request drop after every single cycle. A strobe that arrives while no request is pending is ignored and sets a sticky error flag.

Top module: `dreq_burst_ctrl`

## Requirements
- R1: After the power-on reset (`rst_i`) and after a bus reset (`bus_rst_i`), the register reads 16'h0004. The request, done and error outputs are low at that point.
- R2: A register write stores bits 12..0 of the write data. Bits 15..13 are not stored and always read as zero. The stored value can be read on `cfg_rdata_o` in the cycle after the write.
- R3: In the narrow mode (`wide_mode_i`=0 when the start is taken), each strobe accepted while the request is high counts 2 bytes. The request drops after the strobe that uses up the effective burst length.
- R4: In the wide mode (`wide_mode_i`=1 when the start is taken), each strobe counts 4 bytes. The same burst rule as in R3 applies.
- R5: A burst length that is not aligned to the step is rounded down to the nearest multiple of the step. The step is 2 in the narrow mode and 4 in the wide mode.
- R6: A burst length that rounds to zero is treated as one step. The request then drops after every single strobe.
- R7: When a burst ends and transfer bytes remain, the request is low for exactly one cycle and then high again. The burst length is reloaded from the register at that point.
- R8: When the remaining transfer count reaches zero, the request goes low and stays low. `done_o` is high for exactly one cycle. If the transfer ends partway through a burst, that last burst is shorter.
- R9: A strobe that arrives while the request is low has no effect on any count. It sets `err_o`, which stays high until a reset or a bus reset.
- R10: A start is taken only while no transfer is in progress. A start during a transfer has no effect on the byte count of that transfer.
- R11: A start with a transfer length of zero raises `done_o` for one cycle and never raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| bus_rst_i | input | 1 | Synchronous active-high bus reset, same effect as rst_i |
| cfg_wr_i | input | 1 | Burst length register write enable |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data |
| wide_mode_i | input | 1 | 1 = 4-byte bus cycles, 0 = 2-byte bus cycles, sampled at start |
| start_i | input | 1 | Begin a transfer |
| xfer_len_i | input | XFER_W | Transfer length in bytes, sampled at start |
| dma_strobe_i | input | 1 | One DMA read or write cycle completed |
| dreq_o | output | 1 | DMA request |
| done_o | output | 1 | One-cycle pulse when the transfer is complete |
| err_o | output | 1 | Sticky flag for a strobe received with no request pending |

## Verification
Several properties are checked on every cycle:
- the register value after a bus reset and after each write;
- that done is never high together with the request;
- that a mid-transfer drop of the request lasts a single cycle;
- how the error flag is set and held.

Other behaviour can only be shown by the bench's runs, which cover both bus modes and a range of aligned, misaligned and zero burst settings:
- how many strobes each burst holds;
- how short the final burst is;
- the total byte count;
- that a start during a transfer has no effect.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    localparam int CFG_W   = 16;
    localparam int BURST_W = 13;

    typedef logic [BURST_W-1:0] burst_t;

    localparam burst_t BURST_RST = burst_t'(4);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       wide;
        burst_t     left;
    } seq_ctl_t;

    // bytes moved by one bus cycle
    function automatic burst_t step_of(input logic wide);
        return wide ? burst_t'(4) : burst_t'(2);
    endfunction

    // round down to the step, never below one step
    function automatic burst_t eff_burst(input burst_t raw, input logic wide);
        burst_t m;
        m = raw & ~(step_of(wide) - burst_t'(1));
        if (m == '0) m = step_of(wide);
        return m;
    endfunction

endpackage

// File: rtl/dreq_burst_reg.sv
module dreq_burst_reg
    import dreq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_i,
    input  burst_t             wdata_i,
    output burst_t             burst_o,
    output logic [CFG_W-1:0]   rdata_o
);

    localparam int RESV_W = CFG_W - BURST_W;

    burst_t len_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)      len_q <= BURST_RST;
        else if (wr_i)  len_q <= wdata_i;
    end

    assign burst_o = len_q;

    generate
        if (RESV_W > 0) begin : g_resv
            assign rdata_o = {{RESV_W{1'b0}}, len_q};
        end else begin : g_flat
            assign rdata_o = len_q[CFG_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
    import dreq_pkg::*;
#(
    parameter int XFER_W = 16
)(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [XFER_W-1:0] xfer_len_i,
    input  logic              wide_i,
    input  logic              strobe_i,
    input  burst_t            burst_cfg_i,
    output logic              dreq_o,
    output logic              done_o,
    output logic              err_o
);

    seq_ctl_t          ctl;
    logic [XFER_W-1:0] buf_left;
    logic              done_q;
    logic              err_q;
    burst_t            step_b;
    logic [XFER_W-1:0] step_x;

    assign step_b = step_of(ctl.wide);
    assign step_x = XFER_W'(step_b);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl      <= '{st: ST_IDLE, wide: 1'b0, left: '0};
            buf_left <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (strobe_i && ctl.st != ST_REQ) err_q <= 1'b1;
            case (ctl.st)
                ST_IDLE: begin
                    if (start_i) begin
                        ctl.wide <= wide_i;
                        if (xfer_len_i == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            buf_left <= xfer_len_i;
                            ctl.left <= eff_burst(burst_cfg_i, wide_i);
                            ctl.st   <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (strobe_i) begin
                        buf_left <= buf_left - step_x;
                        ctl.left <= ctl.left - step_b;
                        if (buf_left <= step_x) begin
                            ctl.st <= ST_IDLE;
                            done_q <= 1'b1;
                        end else if (ctl.left <= step_b) begin
                            ctl.st <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    ctl.left <= eff_burst(burst_cfg_i, ctl.wide);
                    ctl.st   <= ST_REQ;
                end
                default: ctl.st <= ST_IDLE;
            endcase
        end
    end

    assign dreq_o = (ctl.st == ST_REQ);
    assign done_o = done_q;
    assign err_o  = err_q;

endmodule

// File: rtl/dreq_burst_ctrl.sv
module dreq_burst_ctrl
    import dreq_pkg::*;
#(
    parameter int XFER_W = 16
)(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_rst_i,
    input  logic              cfg_wr_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic [CFG_W-1:0]  cfg_rdata_o,
    input  logic              wide_mode_i,
    input  logic              start_i,
    input  logic [XFER_W-1:0] xfer_len_i,
    input  logic              dma_strobe_i,
    output logic              dreq_o,
    output logic              done_o,
    output logic              err_o
);

    logic   any_rst;
    burst_t burst_len;
    logic   unused_resv;

    assign any_rst     = rst_i | bus_rst_i;
    assign unused_resv = ^cfg_wdata_i[CFG_W-1:BURST_W];

    dreq_burst_reg u_reg (
        .clk_i   (clk_i),
        .rst_i   (any_rst),
        .wr_i    (cfg_wr_i),
        .wdata_i (cfg_wdata_i[BURST_W-1:0]),
        .burst_o (burst_len),
        .rdata_o (cfg_rdata_o)
    );

    dreq_seq #(.XFER_W(XFER_W)) u_seq (
        .clk_i       (clk_i),
        .rst_i       (any_rst),
        .start_i     (start_i),
        .xfer_len_i  (xfer_len_i),
        .wide_i      (wide_mode_i),
        .strobe_i    (dma_strobe_i),
        .burst_cfg_i (burst_len),
        .dreq_o      (dreq_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

endmodule

// File: rtl/dreq_burst_ctrl_chk.sv
module dreq_burst_ctrl_chk
    import dreq_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             bus_rst_i,
    input logic             cfg_wr_i,
    input logic [CFG_W-1:0] cfg_wdata_i,
    input logic [CFG_W-1:0] cfg_rdata_o,
    input logic             dma_strobe_i,
    input logic             dreq_o,
    input logic             done_o,
    input logic             err_o
);

    p_bus_rst_val_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(bus_rst_i) |-> cfg_rdata_o == CFG_W'(4));

    p_wr_readback_r2: assert property (@(posedge clk_i) disable iff (rst_i || bus_rst_i)
        cfg_wr_i |=> (cfg_rdata_o[BURST_W-1:0] == $past(cfg_wdata_i[BURST_W-1:0]))
                  && (cfg_rdata_o[CFG_W-1:BURST_W] == '0));

    p_gap_one_r7: assert property (@(posedge clk_i) disable iff (rst_i || bus_rst_i)
        ($fell(dreq_o) && !done_o && !$past(bus_rst_i)) |=> dreq_o);

    p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (rst_i || bus_rst_i)
        done_o |-> !dreq_o);

    p_err_set_r9: assert property (@(posedge clk_i) disable iff (rst_i || bus_rst_i)
        (dma_strobe_i && !dreq_o) |=> err_o);

    p_err_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i || bus_rst_i)
        err_o |=> err_o);

endmodule

bind dreq_burst_ctrl dreq_burst_ctrl_chk chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .bus_rst_i    (bus_rst_i),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .dma_strobe_i (dma_strobe_i),
    .dreq_o       (dreq_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/dreq_burst_ctrl_tb_top.sv
`timescale 1ns/1ps
module dreq_burst_ctrl_tb_top;

    localparam int XW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_rst = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          wide = 1'b0;
    logic          start = 1'b0;
    logic [XW-1:0] xlen = '0;
    logic          strobe = 1'b0;
    logic          dreq, done, err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    dreq_burst_ctrl #(.XFER_W(XW)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .bus_rst_i    (bus_rst),
        .cfg_wr_i     (cfg_wr),
        .cfg_wdata_i  (cfg_wdata),
        .cfg_rdata_o  (cfg_rdata),
        .wide_mode_i  (wide),
        .start_i      (start),
        .xfer_len_i   (xlen),
        .dma_strobe_i (strobe),
        .dreq_o       (dreq),
        .done_o       (done),
        .err_o        (err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // one transfer; strobes on every cycle the request is seen high
    task automatic run_xfer(input bit w, input int breg, input int len, input bit poke);
        int step, raw, e, spb, total, remaining, ntot, cur, gap, exp_b;
        bit seen_done;
        string tag;
        step = w ? 4 : 2;
        raw = breg & 16'h1FFF;
        e = raw - (raw % step);
        if (e == 0) e = step;
        if (e == 0 || raw < step) tag = "R6";
        else if (e != raw) tag = "R5";
        else tag = w ? "R4" : "R3";
        spb = e / step;
        total = len / step;
        remaining = total;
        ntot = 0; cur = 0; gap = 0; seen_done = 0;
        write_reg(16'(breg));
        wide = w;
        start = 1'b1;
        xlen = XW'(len);
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (poke) begin
                start = (cyc == 1);
                xlen = XW'(200);
            end
            if (!dreq && cur > 0) begin
                exp_b = (spb < remaining) ? spb : remaining;
                chk(cur == exp_b, tag, cur, exp_b);
                remaining -= cur;
                cur = 0;
            end
            if (done) begin
                seen_done = 1;
                strobe = 1'b0;
                break;
            end
            if (dreq) begin
                if (cur == 0 && ntot > 0) chk(gap == 1, "R7", gap, 1);
                strobe = 1'b1;
                cur++;
                ntot++;
                gap = 0;
            end else begin
                strobe = 1'b0;
                gap++;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen_done, "R8", int'(seen_done), 1);
        chk(ntot == total, poke ? "R10" : (w ? "R4" : "R3"), ntot, total);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!done && !dreq, "R8", int'({done, dreq}), 0);
        end
    endtask

    initial begin
        int bl[8];
        bl = '{0, 1, 2, 3, 5, 6, 12, 16'hE00A};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 power-on values
        chk(cfg_rdata == 16'h0004, "R1", cfg_rdata, 4);
        chk(!dreq && !done && !err, "R1", int'({dreq, done, err}), 0);

        // R2 readback and reserved bits
        write_reg(16'hFFFF);
        chk(cfg_rdata == 16'h1FFF, "R2", cfg_rdata, 16'h1FFF);
        write_reg(16'h0000);
        chk(cfg_rdata == 16'h0000, "R2", cfg_rdata, 0);
        write_reg(16'hA5A4);
        chk(cfg_rdata == 16'h05A4, "R2", cfg_rdata, 16'h05A4);

        // R11 zero-length start
        @(negedge clk);
        start = 1'b1;
        xlen = '0;
        @(negedge clk);
        start = 1'b0;
        chk(done && !dreq, "R11", int'({done, dreq}), 2);
        @(negedge clk);
        chk(!done && !dreq, "R11", int'({done, dreq}), 0);

        // sweep: modes x burst settings x lengths
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < 8; i++) begin
                int st, raw, e;
                st = (w != 0) ? 4 : 2;
                raw = bl[i] & 16'h1FFF;
                e = raw - (raw % st);
                if (e == 0) e = st;
                run_xfer(w[0], bl[i], e * 3, 1'b0);
                run_xfer(w[0], bl[i], e * 2 + st, 1'b0);
            end
        end

        // R10 start during a transfer has no effect
        run_xfer(1'b0, 4, 16, 1'b1);
        run_xfer(1'b1, 8, 24, 1'b1);

        // R9 strobe while idle: error set, counts unaffected
        chk(!err, "R9", err, 0);
        @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk(err, "R9", err, 1);
        run_xfer(1'b0, 6, 18, 1'b0);
        chk(err, "R9", err, 1);

        // R1 bus reset restores values and clears the error
        write_reg(16'h000C);
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        chk(cfg_rdata == 16'h0004, "R1", cfg_rdata, 4);
        chk(!dreq && !done && !err, "R1", int'({dreq, done, err}), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule